// File: doc/BRIEF.md
# Sync Frequency Meter

This block times the horizontal and vertical sync inputs of a display front end in cycles of the oscillator clock that drives it. Both sync inputs are asynchronous. Each one is resynchronised and passed through a filter that drops any pulse too short to be sampled twice, and only its rising edges are used. The horizontal result covers a window of 64 line periods. The vertical result covers the interval between two successive frame pulses. Each result is held in a latch that firmware reads.

A 15-bit counter measures the horizontal window, and the latch keeps its top 11 bits. When frame sync is present, that latch takes the newest finished window on each frame pulse. When frame sync is absent, the latch updates at the end of every window. A 14-bit counter measures the frame interval, and the latch keeps its top 9 bits. Both counters stop at all-ones. A stopped counter means that input is missing: its presence flag clears and its result reads all-ones. Firmware reads the horizontal result as two bytes. A read of the low byte captures the high bits into a shadow register, so the two bytes of a pair always match.

Top module: `sync_freq_meter`

## Requirements
- R1: A sync pulse that is high for only one clock sample never sets a presence flag and never counts as an edge. A pulse seen on two or more samples is accepted.
- R2: With steady line sync of period P cycles, the horizontal result equals (64·P) >> 4. This is the top 11 bits of a 15-bit count.
- R3: With steady frame sync of period F cycles, the vertical result equals F >> 5. It changes only in the cycle that follows an accepted frame edge, or when the vertical counter stops at all-ones.
- R4: While frame sync is present, the horizontal latch changes only on accepted frame edges. The change is seen 4 clock edges after the first clock edge that samples the raw frame pulse high.
- R5: While frame sync is absent, the horizontal latch loads at the end of every 64-line window.
- R6: A counter that reaches all-ones stops there. The horizontal result then reads 0x7FF and the vertical result reads 0x1FF.
- R7: A presence flag is set by an accepted rising edge. It clears when that input's counter reaches all-ones with no edge.
- R8: h_lo_o shows bits [7:0] of the horizontal latch at all times. h_hi_o shows latch bits [10:8] as captured on the last cycle with rd_lo_i high, and it holds that value otherwise.
- R9: After reset, both results, h_hi_o and both presence flags are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock, which is also the unit of measurement |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync_i | input | 1 | Raw line sync, asynchronous |
| vsync_i | input | 1 | Raw frame sync, asynchronous |
| rd_lo_i | input | 1 | Low-byte read strobe; captures the high bits into the shadow |
| h_lo_o | output | 8 | Horizontal result bits [7:0] |
| h_hi_o | output | 3 | Horizontal result bits [10:8], from the shadow |
| v_period_o | output | 9 | Vertical result |
| h_present_o | output | 1 | Line sync present |
| v_present_o | output | 1 | Frame sync present |

## Verification
A raw edge reaches a result latch 4 clock edges after it is first sampled: two synchroniser stages, one stage to compare, and the latch. A low-byte strobe reaches h_hi_o one edge later. The table-driven checks wait for several full windows and frame periods before they sample, always at the falling clock edge, so a partial first window cannot affect the result. The hold test logs the cycle of every frame pulse it drives. It requires each change of a result latch to fall exactly 4 cycles after the last logged frame pulse, which turns the R4 timing into a check made on every cycle.

// File: rtl/sfm_pkg.sv
package sfm_pkg;
    localparam int SFM_SYNC_STAGES = 2;
    localparam int SFM_H_CNT_W     = 15;
    localparam int SFM_H_RES_W     = 11;
    localparam int SFM_LINES_LOG2  = 6;
    localparam int SFM_V_CNT_W     = 14;
    localparam int SFM_V_RES_W     = 9;
    localparam int SFM_BYTE_W      = 8;
endpackage

// File: rtl/sfm_edge_front.sv
module sfm_edge_front #(
    parameter int STAGES = sfm_pkg::SFM_SYNC_STAGES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_in,
    output logic rise_o
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              last;
        logic              filt;
    } fe_t;

    fe_t st_d, st_q;
    logic synced;

    always_comb begin
        st_d       = st_q;
        synced     = st_q.chain[STAGES-1];
        st_d.chain = {st_q.chain[STAGES-2:0], sync_in};
        st_d.last  = synced;
        // level must persist across two samples before the filter follows it
        if (synced == st_q.last) begin
            st_d.filt = synced;
        end
        rise_o = st_d.filt & ~st_q.filt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/sfm_h_meter.sv
module sfm_h_meter #(
    parameter int CNT_W      = sfm_pkg::SFM_H_CNT_W,
    parameter int RES_W      = sfm_pkg::SFM_H_RES_W,
    parameter int LINES_LOG2 = sfm_pkg::SFM_LINES_LOG2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             h_rise,
    input  logic             v_rise,
    input  logic             v_present,
    output logic [RES_W-1:0] lat_o,
    output logic             present_o,
    output logic             sat_o
);
    typedef struct packed {
        logic [LINES_LOG2-1:0] lines;
        logic [CNT_W-1:0]      cnt;
        logic [RES_W-1:0]      win;
        logic [RES_W-1:0]      lat;
        logic                  present;
    } hm_t;

    hm_t  st_d, st_q;
    logic sat;
    logic last_line;

    always_comb begin
        st_d      = st_q;
        sat       = (st_q.cnt == {CNT_W{1'b1}});
        last_line = (st_q.lines == {LINES_LOG2{1'b1}});
        if (!sat) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        if (h_rise) begin
            st_d.present = 1'b1;
            if (sat) begin
                // restart a clean window after a stall
                st_d.lines = '0;
                st_d.cnt   = {{(CNT_W-1){1'b0}}, 1'b1};
            end else if (last_line) begin
                st_d.lines = '0;
                st_d.cnt   = {{(CNT_W-1){1'b0}}, 1'b1};
                st_d.win   = st_q.cnt[CNT_W-1 -: RES_W];
                if (!v_present) begin
                    st_d.lat = st_q.cnt[CNT_W-1 -: RES_W];
                end
            end else begin
                st_d.lines = st_q.lines + 1'b1;
            end
        end else if (sat) begin
            st_d.present = 1'b0;
            st_d.lines   = '0;
            st_d.win     = {RES_W{1'b1}};
            if (!v_present) begin
                st_d.lat = {RES_W{1'b1}};
            end
        end
        if (v_present && v_rise) begin
            st_d.lat = st_q.win;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lat_o     = st_q.lat;
    assign present_o = st_q.present;
    assign sat_o     = sat;
endmodule

// File: rtl/sfm_v_meter.sv
module sfm_v_meter #(
    parameter int CNT_W = sfm_pkg::SFM_V_CNT_W,
    parameter int RES_W = sfm_pkg::SFM_V_RES_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             v_rise,
    output logic [RES_W-1:0] lat_o,
    output logic             present_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [RES_W-1:0] lat;
        logic             present;
    } vm_t;

    vm_t  st_d, st_q;
    logic sat;

    always_comb begin
        st_d = st_q;
        sat  = (st_q.cnt == {CNT_W{1'b1}});
        if (!sat) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        if (v_rise) begin
            st_d.present = 1'b1;
            st_d.cnt     = {{(CNT_W-1){1'b0}}, 1'b1};
            if (!sat) begin
                st_d.lat = st_q.cnt[CNT_W-1 -: RES_W];
            end
        end else if (sat) begin
            st_d.present = 1'b0;
            st_d.lat     = {RES_W{1'b1}};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lat_o     = st_q.lat;
    assign present_o = st_q.present;
endmodule

// File: rtl/sync_freq_meter.sv
module sync_freq_meter #(
    parameter int SYNC_STAGES = sfm_pkg::SFM_SYNC_STAGES,
    parameter int H_CNT_W     = sfm_pkg::SFM_H_CNT_W,
    parameter int H_RES_W     = sfm_pkg::SFM_H_RES_W,
    parameter int LINES_LOG2  = sfm_pkg::SFM_LINES_LOG2,
    parameter int V_CNT_W     = sfm_pkg::SFM_V_CNT_W,
    parameter int V_RES_W     = sfm_pkg::SFM_V_RES_W
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  hsync_i,
    input  logic                                  vsync_i,
    input  logic                                  rd_lo_i,
    output logic [sfm_pkg::SFM_BYTE_W-1:0]        h_lo_o,
    output logic [H_RES_W-sfm_pkg::SFM_BYTE_W-1:0] h_hi_o,
    output logic [V_RES_W-1:0]                    v_period_o,
    output logic                                  h_present_o,
    output logic                                  v_present_o
);
    localparam int BW   = sfm_pkg::SFM_BYTE_W;
    localparam int HI_W = H_RES_W - BW;

    logic               h_rise;
    logic               v_rise;
    logic               h_sat;
    logic [H_RES_W-1:0] h_lat;

    typedef struct packed {
        logic [HI_W-1:0] hi;
    } rd_t;

    rd_t rd_d, rd_q;

    sfm_edge_front #(.STAGES(SYNC_STAGES)) u_h_front (
        .clk(clk), .rst_n(rst_n), .sync_in(hsync_i), .rise_o(h_rise)
    );

    sfm_edge_front #(.STAGES(SYNC_STAGES)) u_v_front (
        .clk(clk), .rst_n(rst_n), .sync_in(vsync_i), .rise_o(v_rise)
    );

    sfm_v_meter #(.CNT_W(V_CNT_W), .RES_W(V_RES_W)) u_v_meter (
        .clk(clk), .rst_n(rst_n), .v_rise(v_rise),
        .lat_o(v_period_o), .present_o(v_present_o)
    );

    sfm_h_meter #(.CNT_W(H_CNT_W), .RES_W(H_RES_W), .LINES_LOG2(LINES_LOG2)) u_h_meter (
        .clk(clk), .rst_n(rst_n), .h_rise(h_rise), .v_rise(v_rise),
        .v_present(v_present_o), .lat_o(h_lat),
        .present_o(h_present_o), .sat_o(h_sat)
    );

    always_comb begin
        rd_d = rd_q;
        if (rd_lo_i) begin
            rd_d.hi = h_lat[H_RES_W-1:BW];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign h_lo_o = h_lat[BW-1:0];
    assign h_hi_o = rd_q.hi;
endmodule

// File: rtl/sfm_checker.sv
module sfm_checker #(
    parameter int H_RES_W = sfm_pkg::SFM_H_RES_W,
    parameter int V_RES_W = sfm_pkg::SFM_V_RES_W,
    parameter int HI_W    = sfm_pkg::SFM_H_RES_W - sfm_pkg::SFM_BYTE_W
) (
    input logic               clk,
    input logic               rst_n,
    input logic               rd_lo,
    input logic [HI_W-1:0]    h_hi,
    input logic [H_RES_W-1:0] h_lat,
    input logic [V_RES_W-1:0] v_period,
    input logic               v_present,
    input logic               h_present,
    input logic               v_rise,
    input logic               h_rise,
    input logic               h_sat
);
    AST_HI_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_lo |=> $stable(h_hi)); // R8

    AST_VLAT_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(v_period) && !$fell(v_present) && v_period != '1) |-> $past(v_rise)); // R3

    AST_HLAT_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(v_present) && !$stable(h_lat)) |-> $past(v_rise)); // R4

    AST_VP_SET: assert property (@(posedge clk) disable iff (!rst_n)
        v_rise |=> v_present); // R7

    AST_HP_SET: assert property (@(posedge clk) disable iff (!rst_n)
        h_rise |=> h_present); // R7

    AST_HP_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(h_present) |-> $past(h_sat)); // R7

    AST_SAT_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(v_present) |-> (v_period == '1)); // R6
endmodule

bind sync_freq_meter sfm_checker #(
    .H_RES_W(H_RES_W), .V_RES_W(V_RES_W), .HI_W(HI_W)
) u_sfm_checker (
    .clk(clk), .rst_n(rst_n), .rd_lo(rd_lo_i), .h_hi(h_hi_o), .h_lat(h_lat),
    .v_period(v_period_o), .v_present(v_present_o), .h_present(h_present_o),
    .v_rise(v_rise), .h_rise(h_rise), .h_sat(h_sat)
);

// File: tb/sync_freq_meter_bench.sv
module sync_freq_meter_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       hsync;
    logic       vsync;
    logic       rd_lo;
    logic [7:0] h_lo;
    logic [2:0] h_hi;
    logic [8:0] v_per_o;
    logic       h_pres;
    logic       v_pres;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int h_per = 0;
    int h_w = 4;
    int v_per = 0;
    int v_w = 4;
    int v_rise_cyc = -100;
    logic mon_en = 1'b0;
    int mon_changes = 0;
    int mon_bad = 0;
    logic [7:0] prev_lo = '0;
    logic [8:0] prev_v = '0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sync_freq_meter u_sync_freq_meter (
        .clk(clk), .rst_n(rst_n), .hsync_i(hsync), .vsync_i(vsync),
        .rd_lo_i(rd_lo), .h_lo_o(h_lo), .h_hi_o(h_hi), .v_period_o(v_per_o),
        .h_present_o(h_pres), .v_present_o(v_pres)
    );

    typedef struct packed {
        int   hper;
        int   vper;
        int   settle;
        int   hlat;
        int   vlat;
        logic hp;
        logic vp;
    } vec_t;

    localparam int NVEC = 4;
    localparam vec_t VECS [NVEC] = '{
        '{100,  8000, 22000,  400, 250, 1'b1, 1'b1},
        '{ 64,     0, 34000,  256, 511, 1'b1, 1'b0},
        '{200, 12000, 42000,  800, 375, 1'b1, 1'b1},
        '{  0,  6000, 40000, 2047, 187, 1'b0, 1'b1}
    };

    initial begin
        hsync = 1'b0;
        forever begin
            if (h_per == 0) begin
                hsync = 1'b0;
                @(negedge clk);
            end else begin
                hsync = 1'b1;
                repeat (h_w) @(negedge clk);
                hsync = 1'b0;
                repeat (h_per - h_w) @(negedge clk);
            end
        end
    end

    initial begin
        vsync = 1'b0;
        forever begin
            if (v_per == 0) begin
                vsync = 1'b0;
                @(negedge clk);
            end else begin
                vsync = 1'b1;
                v_rise_cyc = cyc;
                repeat (v_w) @(negedge clk);
                vsync = 1'b0;
                repeat (v_per - v_w) @(negedge clk);
            end
        end
    end

    // R4 / R3 timing monitor: latch changes must land 4 edges after a frame pulse
    always @(negedge clk) begin
        if (mon_en) begin
            if (h_lo != prev_lo) begin
                mon_changes++;
                if (cyc - v_rise_cyc != 4) mon_bad++;
            end
            if (v_per_o != prev_v) begin
                if (cyc - v_rise_cyc != 4) mon_bad++;
            end
        end
        prev_lo = h_lo;
        prev_v  = v_per_o;
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic read_h(output int val);
        rd_lo = 1'b1;
        @(negedge clk);
        rd_lo = 1'b0;
        val = {21'd0, h_hi, h_lo};
    endtask

    initial begin
        repeat (199000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 199000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int hval;
        int prev_hi;
        rst_n = 1'b0;
        rd_lo = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        check("R9 h_lo", int'(h_lo), 0);
        check("R9 h_hi", int'(h_hi), 0);
        check("R9 v_period", int'(v_per_o), 0);
        check("R9 h_present", int'(h_pres), 0);
        check("R9 v_present", int'(v_pres), 0);
        prev_hi = 0;

        for (int i = 0; i < NVEC; i++) begin
            h_per = VECS[i].hper;
            v_per = VECS[i].vper;
            h_w   = 4;
            repeat (VECS[i].settle) @(negedge clk);
            // R8: high byte holds its shadow until the next low-byte read
            check("R8 hi frozen", int'(h_hi), prev_hi);
            read_h(hval);
            // R2 / R5 / R6 horizontal result
            check((i == 1) ? "R5 h result" : (i == 3) ? "R6 h result" : "R2 h result",
                  hval, VECS[i].hlat);
            check((i == 1) ? "R6 v result" : "R3 v result", int'(v_per_o), VECS[i].vlat);
            check("R7 h_present", int'(h_pres), int'(VECS[i].hp));
            check("R7 v_present", int'(v_pres), int'(VECS[i].vp));
            prev_hi = VECS[i].hlat >> 8;
        end

        // R1: single-sample pulses are noise
        h_w   = 1;
        h_per = 100;
        repeat (3000) @(negedge clk);
        check("R1 narrow pulse present", int'(h_pres), 0);
        check("R1 narrow pulse result", int'(h_lo), 255);
        h_w = 2;
        repeat (1000) @(negedge clk);
        check("R1 two-sample pulse present", int'(h_pres), 1);

        // R4: locked to frame pulses while frame sync is present
        h_w = 4;
        mon_en = 1'b1;
        repeat (20000) @(negedge clk);
        mon_en = 1'b0;
        check("R4 misaligned latch changes", mon_bad, 0);
        check("R4 latch changed at all", int'(mon_changes > 0), 1);
        read_h(hval);
        check("R4 h result", hval, 400);
        check("R3 v result hold", int'(v_per_o), 187);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule